// File: doc/BRIEF.md
# PCI Function Interrupt Pin Router

This block merges the legacy level interrupt requests of the PCI functions inside a chipset onto eight shared interrupt request lanes, named A to H. Each internal device has up to eight functions, and each function drives one active-high request. Routing takes two programmable stages. First, a per-device pin-assignment register places each function on one of four INTx lanes (INTA# to INTD#), or on no lane at all. Second, a per-device route register sends each of that device's four INTx lanes to one of the eight shared lanes.

Each shared output is the OR of every INTx lane routed to it, and it is registered. A shared level interrupt therefore stays asserted until every source behind it has released. Firmware programs both register kinds through a single-cycle write port. For each function the block also presents a read-only Interrupt Pin value that mirrors the pin-assignment field. No write path can change that value.

Top module: `pci_intpin_router`

## Requirements
- R1: After synchronous active-low reset every pin-assignment field is 0, device route fields map INTA#→A, INTB#→B, INTC#→C, INTD#→D, and all eight lane outputs are low.
- R2: A pin-assignment write (`wr_sel_i`=0) stores the field of function f from `wr_data_i[4f+2:4f]`. Code 1 places the function on INTA#, 2 on INTB#, 3 on INTC# and 4 on INTD#.
- R3: Several functions of one device may select the same INTx lane. That lane is active while any of their requests is high.
- R4: A function whose field is 0, or a reserved code 5–7, never contributes to any lane, even while its request is high.
- R5: A route write (`wr_sel_i`=1) stores the target of INTx lane i (i=0 for INTA#) from `wr_data_i[3i+2:3i]`. Codes 0–7 select shared lanes A–H (output bits 0–7). Lanes of different devices may share a target.
- R6: Each lane output is the OR of all INTx lanes routed to it. It stays high until every contributing request is low.
- R7: `int_pin_o` bits [3k+2:3k], with k = device*8 + function, always equal the stored pin-assignment field, reserved codes included. Writes with `wr_sel_i` of 2 (the pin read-back space) or 3, and writes to a device index at or above the device count, change no register and no output.
- R8: A register write takes effect at the clock edge that samples it: `int_pin_o` shows the new value after that edge, and the lane outputs follow one edge later. A request change appears on the lane outputs exactly one clock edge after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fn_req_i | input | 40 | Level request per function, bit device*8+function |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 pin assignment, 1 route, 2 pin read-back (ignored), 3 reserved (ignored) |
| wr_dev_i | input | 3 | Device index of the write |
| wr_data_i | input | 32 | Write data |
| pirq_o | output | 8 | Registered shared lane levels, bit 0 = lane A |
| int_pin_o | output | 120 | Read-only Interrupt Pin value per function, 3 bits each |

## Verification
The router is driven with random pin codes (reserved ones included), random route codes and random request vectors. A model computes every lane, so sharing, suppression and cross-device merging are all compared in one pass. Directed cases separate several effects that random patterns can hide. Two functions sharing a lane, with one of them released, shows OR holding against last-writer behaviour. Requests from functions with no lane, or with reserved codes, show that suppression really takes place. Two devices aimed at one lane check cross-device merging. Ignored writes distinguish register decode from data decode. A write made while requests are held separates the two cycles of latency.

// File: rtl/irq_rt_pkg.sv
// Package: shared constants, write-select codes and pin-code decoding for
// the PCI function interrupt pin router. Assumes four INTx lanes per device.
package irq_rt_pkg;

    localparam int INTX_LANES = 4;
    localparam int PIN_W      = 3;
    localparam int NIBBLE_W   = 4;

    typedef enum logic [1:0] {
        SEL_PIN   = 2'd0,
        SEL_ROUTE = 2'd1,
        SEL_PINRO = 2'd2,
        SEL_RSVD  = 2'd3
    } wr_sel_e;

    // Turn a pin-assignment code into a one-hot INTx lane vector; 0 and 5..7 give none.
    function automatic logic [INTX_LANES-1:0] pin_to_lane(input logic [PIN_W-1:0] code);
        logic [INTX_LANES-1:0] lane;
        lane = '0;
        for (int i = 0; i < INTX_LANES; i++) begin
            if (code == PIN_W'(i + 1)) lane[i] = 1'b1;
        end
        return lane;
    endfunction

endpackage

// File: rtl/irq_rt_regs.sv
// Register file: per-device pin-assignment and route registers.
// Assumes a single write port; writes to an unused select or an absent
// device are dropped. Values appear at the outputs after the write edge.
module irq_rt_regs
    import irq_rt_pkg::*;
#(
    parameter int NUM_DEV  = 5,
    parameter int NUM_FUNC = 8,
    parameter int NUM_PIRQ = 8,
    localparam int DEV_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
    localparam int RW      = (NUM_PIRQ > 1) ? $clog2(NUM_PIRQ) : 1,
    localparam int DATA_W  = NUM_FUNC * NIBBLE_W,
    localparam int PINV_W  = NUM_FUNC * PIN_W,
    localparam int ROUTE_W = INTX_LANES * RW
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en_i,
    input  logic [1:0]                  wr_sel_i,
    input  logic [DEV_W-1:0]            wr_dev_i,
    input  logic [DATA_W-1:0]           wr_data_i,
    output logic [NUM_DEV*PINV_W-1:0]   pin_flat_o,
    output logic [NUM_DEV*ROUTE_W-1:0]  route_flat_o
);

    localparam logic [DEV_W-1:0] LAST_DEV = DEV_W'(NUM_DEV - 1);

    // Identity routing used at reset: INTx lane i goes to shared lane i.
    function automatic logic [ROUTE_W-1:0] ident_route();
        logic [ROUTE_W-1:0] r;
        for (int i = 0; i < INTX_LANES; i++) r[i*RW +: RW] = RW'(i);
        return r;
    endfunction

    localparam logic [ROUTE_W-1:0] ROUTE_RST = ident_route();

    logic [PINV_W-1:0]  pin_q   [NUM_DEV];
    logic [ROUTE_W-1:0] route_q [NUM_DEV];
    logic               dev_ok;

    // Qualify the device index of a write.
    always_comb dev_ok = (wr_dev_i <= LAST_DEV);

    // Hold and update the pin-assignment and route registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int d = 0; d < NUM_DEV; d++) begin
                pin_q[d]   <= '0;
                route_q[d] <= ROUTE_RST;
            end
        end else if (wr_en_i && dev_ok) begin
            case (wr_sel_i)
                SEL_PIN: begin
                    for (int f = 0; f < NUM_FUNC; f++)
                        pin_q[wr_dev_i][f*PIN_W +: PIN_W] <= wr_data_i[f*NIBBLE_W +: PIN_W];
                end
                SEL_ROUTE: begin
                    route_q[wr_dev_i] <= wr_data_i[ROUTE_W-1:0];
                end
                default: ;
            endcase
        end
    end

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_flat
        assign pin_flat_o[d*PINV_W +: PINV_W]     = pin_q[d];
        assign route_flat_o[d*ROUTE_W +: ROUTE_W] = route_q[d];
    end

    // R1: the first cycle after reset shows identity routes and empty pins.
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (route_q[0] == ROUTE_RST && pin_q[0] == '0));

    // R7: writes to the read-back or reserved space or an absent device change nothing.
    assert_ignored_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (wr_sel_i == SEL_PINRO || wr_sel_i == SEL_RSVD || !dev_ok))
        |=> ($stable(pin_flat_o) && $stable(route_flat_o)));

    // R5: a route write is visible right after its edge.
    assert_route_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == SEL_ROUTE && dev_ok)
        |=> (route_q[$past(wr_dev_i)] == $past(wr_data_i[ROUTE_W-1:0])));

endmodule

// File: rtl/irq_rt_dev_lanes.sv
// Per-device lane merge: ORs each function's request onto the INTx lane
// chosen by its pin-assignment field. Codes 0 and 5..7 drop the request.
// Purely combinational; the clock only serves the local assertion.
module irq_rt_dev_lanes
    import irq_rt_pkg::*;
#(
    parameter int NUM_FUNC = 8,
    localparam int PINV_W  = NUM_FUNC * PIN_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_FUNC-1:0]   req_i,
    input  logic [PINV_W-1:0]     pin_i,
    output logic [INTX_LANES-1:0] intx_o
);

    logic [INTX_LANES-1:0] fn_lane [NUM_FUNC];

    for (genvar f = 0; f < NUM_FUNC; f++) begin : g_fn
        // Gate one function's decoded lane with its request.
        always_comb fn_lane[f] = req_i[f] ? pin_to_lane(pin_i[f*PIN_W +: PIN_W]) : '0;
    end

    // OR all functions of the device onto the four lanes.
    always_comb begin
        intx_o = '0;
        for (int f = 0; f < NUM_FUNC; f++) intx_o = intx_o | fn_lane[f];
    end

    // R4: with no request raised the device drives no lane.
    assert_quiet_dev_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == '0) |-> (intx_o == '0));

endmodule

// File: rtl/irq_rt_pirq_merge.sv
// Shared-lane merge: sends every device INTx lane to the shared lane chosen
// by that device's route field, ORs all contributors and registers the result.
module irq_rt_pirq_merge
    import irq_rt_pkg::*;
#(
    parameter int NUM_DEV  = 5,
    parameter int NUM_PIRQ = 8,
    localparam int RW      = (NUM_PIRQ > 1) ? $clog2(NUM_PIRQ) : 1,
    localparam int ROUTE_W = INTX_LANES * RW,
    localparam int NLANE   = NUM_DEV * INTX_LANES
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NLANE-1:0]           intx_i,
    input  logic [NUM_DEV*ROUTE_W-1:0] route_i,
    output logic [NUM_PIRQ-1:0]        pirq_o
);

    logic [NUM_PIRQ-1:0] pirq_next;
    logic [NUM_PIRQ-1:0] pirq_q;

    // Scatter each active INTx lane onto its target shared lane.
    always_comb begin
        pirq_next = '0;
        for (int k = 0; k < NLANE; k++) begin
            if (intx_i[k]) pirq_next[route_i[k*RW +: RW]] = 1'b1;
        end
    end

    // Register the merged shared lanes.
    always_ff @(posedge clk) begin
        if (!rst_n) pirq_q <= '0;
        else        pirq_q <= pirq_next;
    end

    assign pirq_o = pirq_q;

    // R6: no active INTx lane in a cycle leaves every shared lane low next cycle.
    assert_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(intx_i == '0)) |-> (pirq_o == '0));

    // R6: any active INTx lane raises at least one shared lane next cycle.
    assert_any_raises_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(intx_i != '0)) |-> (pirq_o != '0));

endmodule

// File: rtl/pci_intpin_router.sv
// Top: PCI function interrupt pin router. Two programmable stages
// (function -> INTx, INTx -> shared lane) feed eight registered level
// outputs. The Interrupt Pin value of each function is read-only and
// mirrors its pin-assignment field. Synchronous active-low reset.
module pci_intpin_router
    import irq_rt_pkg::*;
#(
    parameter int NUM_DEV  = 5,
    parameter int NUM_FUNC = 8,
    parameter int NUM_PIRQ = 8,
    localparam int DEV_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
    localparam int RW      = (NUM_PIRQ > 1) ? $clog2(NUM_PIRQ) : 1,
    localparam int DATA_W  = NUM_FUNC * NIBBLE_W,
    localparam int PINV_W  = NUM_FUNC * PIN_W,
    localparam int ROUTE_W = INTX_LANES * RW
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_DEV*NUM_FUNC-1:0]  fn_req_i,
    input  logic                         wr_en_i,
    input  logic [1:0]                   wr_sel_i,
    input  logic [DEV_W-1:0]             wr_dev_i,
    input  logic [DATA_W-1:0]            wr_data_i,
    output logic [NUM_PIRQ-1:0]          pirq_o,
    output logic [NUM_DEV*PINV_W-1:0]    int_pin_o
);

    logic [NUM_DEV*PINV_W-1:0]     pin_flat;
    logic [NUM_DEV*ROUTE_W-1:0]    route_flat;
    logic [NUM_DEV*INTX_LANES-1:0] intx_flat;

    irq_rt_regs #(
        .NUM_DEV  (NUM_DEV),
        .NUM_FUNC (NUM_FUNC),
        .NUM_PIRQ (NUM_PIRQ)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_en_i),
        .wr_sel_i     (wr_sel_i),
        .wr_dev_i     (wr_dev_i),
        .wr_data_i    (wr_data_i),
        .pin_flat_o   (pin_flat),
        .route_flat_o (route_flat)
    );

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        irq_rt_dev_lanes #(
            .NUM_FUNC (NUM_FUNC)
        ) u_lanes (
            .clk    (clk),
            .rst_n  (rst_n),
            .req_i  (fn_req_i[d*NUM_FUNC +: NUM_FUNC]),
            .pin_i  (pin_flat[d*PINV_W +: PINV_W]),
            .intx_o (intx_flat[d*INTX_LANES +: INTX_LANES])
        );
    end

    irq_rt_pirq_merge #(
        .NUM_DEV  (NUM_DEV),
        .NUM_PIRQ (NUM_PIRQ)
    ) u_merge (
        .clk     (clk),
        .rst_n   (rst_n),
        .intx_i  (intx_flat),
        .route_i (route_flat),
        .pirq_o  (pirq_o)
    );

    // The Interrupt Pin value is a read-only view of the stored field.
    assign int_pin_o = pin_flat;

    // R8: a pin-assignment write is visible on the Interrupt Pin view after its edge.
    assert_pin_visible_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == SEL_PIN && wr_dev_i == '0)
        |=> (int_pin_o[PIN_W-1:0] == $past(wr_data_i[PIN_W-1:0])));

endmodule

// File: tb/tb_pci_intpin_router.sv
module tb_pci_intpin_router;

    localparam int ND = 5;
    localparam int NF = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [ND*NF-1:0] fn_req = '0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = '0;
    logic [2:0]    wr_dev = '0;
    logic [31:0]   wr_data = '0;
    logic [7:0]    pirq;
    logic [ND*NF*3-1:0] int_pin;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int m_pin   [ND][NF];
    int m_route [ND][4];

    pci_intpin_router dut (
        .clk(clk), .rst_n(rst_n), .fn_req_i(fn_req), .wr_en_i(wr_en),
        .wr_sel_i(wr_sel), .wr_dev_i(wr_dev), .wr_data_i(wr_data),
        .pirq_o(pirq), .int_pin_o(int_pin)
    );

    always #2.5 clk = ~clk;

    function automatic logic [7:0] exp_pirq(input logic [ND*NF-1:0] req);
        logic [7:0] p = '0;
        for (int d = 0; d < ND; d++)
            for (int f = 0; f < NF; f++)
                if (req[d*NF+f] && m_pin[d][f] >= 1 && m_pin[d][f] <= 4)
                    p[m_route[d][m_pin[d][f]-1]] = 1'b1;
        return p;
    endfunction

    task automatic chk_pirq(input string tag, input logic [7:0] exp);
        checks++;
        if (pirq !== exp) begin
            errors++;
            $display("FAIL %s: pirq got %h expected %h", tag, pirq, exp);
        end
    endtask

    task automatic chk_pins(input string tag);
        logic [ND*NF*3-1:0] e;
        for (int k = 0; k < ND*NF; k++) e[k*3 +: 3] = 3'(m_pin[k/NF][k%NF]);
        checks++;
        if (int_pin !== e) begin
            errors++;
            $display("FAIL %s: int_pin got %h expected %h", tag, int_pin, e);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [2:0] dev, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_dev = dev; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
        if (dev < ND) begin
            if (sel == 2'd0) for (int f = 0; f < NF; f++) m_pin[dev][f] = int'(data[f*4 +: 3]);
            if (sel == 2'd1) for (int i = 0; i < 4; i++) m_route[dev][i] = int'(data[i*3 +: 3]);
        end
    endtask

    function automatic logic [31:0] pin_word(input int c0, input int c1, input int c2,
                                             input int c3, input int c4, input int c5,
                                             input int c6, input int c7);
        return {1'b0, 3'(c7), 1'b0, 3'(c6), 1'b0, 3'(c5), 1'b0, 3'(c4),
                1'b0, 3'(c3), 1'b0, 3'(c2), 1'b0, 3'(c1), 1'b0, 3'(c0)};
    endfunction

    function automatic logic [31:0] route_word(input int a, input int b, input int c, input int d);
        return {20'd0, 3'(d), 3'(c), 3'(b), 3'(a)};
    endfunction

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] old_e;
        void'($urandom(32'h5eed_1234));
        for (int d = 0; d < ND; d++) begin
            for (int f = 0; f < NF; f++) m_pin[d][f] = 0;
            for (int i = 0; i < 4; i++) m_route[d][i] = i;
        end
        fn_req = '1;
        repeat (3) @(negedge clk);
        chk_pirq("R1 during reset", 8'h00);
        rst_n = 1'b1;
        settle();
        // R1/R4: all fields zero, every request high, lanes stay low.
        chk_pirq("R1 reset with requests high", 8'h00);
        chk_pins("R1 pins zero after reset");

        // R1/R2: identity routes, dev0 functions on each INTx lane.
        fn_req = '0;
        wr(2'd0, 3'd0, pin_word(1, 2, 3, 4, 0, 0, 0, 0));
        for (int i = 0; i < 4; i++) begin
            fn_req = '0; fn_req[i] = 1'b1;
            settle();
            chk_pirq("R1 R2 identity route lane", 8'(1 << i));
        end
        chk_pins("R2 pin readback");

        // R3/R6: two functions share INTB#, release one then the other.
        wr(2'd0, 3'd1, pin_word(2, 2, 0, 0, 0, 0, 0, 0));
        wr(2'd1, 3'd1, route_word(0, 5, 0, 0));
        fn_req = '0; fn_req[NF+0] = 1'b1; fn_req[NF+1] = 1'b1;
        settle();
        chk_pirq("R3 shared lane both", 8'h20);
        fn_req[NF+0] = 1'b0;
        settle();
        chk_pirq("R6 shared lane one left", 8'h20);
        fn_req[NF+1] = 1'b0;
        settle();
        chk_pirq("R6 shared lane released", 8'h00);

        // R4: field 0 and reserved codes never contribute.
        wr(2'd0, 3'd2, pin_word(0, 5, 6, 7, 0, 0, 0, 0));
        fn_req = '0; fn_req[2*NF +: NF] = '1;
        settle();
        chk_pirq("R4 none or reserved code", 8'h00);
        chk_pins("R7 reserved code readback");

        // R5: lanes of two devices share target G.
        wr(2'd1, 3'd0, route_word(6, 1, 2, 3));
        wr(2'd0, 3'd3, pin_word(0, 0, 0, 0, 0, 0, 0, 2));
        wr(2'd1, 3'd3, route_word(0, 6, 0, 0));
        fn_req = '0; fn_req[0] = 1'b1; fn_req[3*NF+7] = 1'b1;
        settle();
        chk_pirq("R5 cross device share", 8'h40);
        fn_req[0] = 1'b0;
        settle();
        chk_pirq("R5 cross device one left", 8'h40);

        // R7: ignored writes (read-back space, reserved select, absent device).
        fn_req = '1;
        settle();
        old_e = exp_pirq(fn_req);
        chk_pirq("R7 before ignored writes", old_e);
        wr(2'd2, 3'd0, 32'h4444_4444);
        wr(2'd3, 3'd1, 32'hffff_ffff);
        wr(2'd0, 3'd5, 32'h1111_1111);
        wr(2'd1, 3'd7, 32'h0000_0000);
        settle();
        chk_pirq("R7 after ignored writes", old_e);
        chk_pins("R7 pins unchanged");

        // R8: write while requests held: pins immediately, lanes one edge later.
        fn_req = '0; fn_req[4*NF+3] = 1'b1;
        settle();
        old_e = exp_pirq(fn_req);
        chk_pirq("R8 before write", old_e);
        wr(2'd0, 3'd4, pin_word(0, 0, 0, 3, 0, 0, 0, 0));
        chk_pirq("R8 lanes still old after write edge", old_e);
        chk_pins("R8 pins new after write edge");
        @(negedge clk);
        chk_pirq("R8 lanes new one edge later", exp_pirq(fn_req));

        // R8: one-cycle request latency.
        fn_req = '0;
        settle();
        fn_req[4*NF+3] = 1'b1;
        #1;
        chk_pirq("R8 not yet sampled", 8'h00);
        @(negedge clk);
        chk_pirq("R8 one edge latency", exp_pirq(fn_req));

        // Random mix over R2 R5 R6.
        for (int it = 0; it < 80; it++) begin
            logic [2:0]  rd;
            logic [31:0] data;
            rd = 3'($urandom_range(0, ND - 1));
            data = $urandom;
            wr(($urandom_range(0, 3) == 0) ? 2'd1 : 2'd0, rd, data);
            fn_req = {$urandom, $urandom};
            settle();
            chk_pirq("R6 random mix", exp_pirq(fn_req));
            if (it % 10 == 0) chk_pins("R7 random readback");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule